// File: doc/BRIEF.md
# Interrupt Line Status and Request Router

This block sits at the front of an interrupt controller and serves 32 interrupt lines. Each line has its own polarity setting. That setting turns the pin level into a raw status bit. Each line also has a mode bit. In level mode the line reports the raw bit as it is. In sticky mode the line reports a latched bit that captures every 0-to-1 transition of the raw status and holds it until software clears it by writing a 1. The per-line status vector is always readable on a dedicated output.

Two processor request outputs come from the status vector. A line is eligible when its status and its enable bit are both set. A per-line fast-select bit sends the line to the fast request instead of the normal one. On each request the lowest-numbered eligible line wins, and its index is presented next to the request. The two requests also appear as a processor pending-interrupt byte.

All state sits in a single register stage. The status reflects the pins as sampled at the most recent clock edge. A configuration write takes effect from the edge that captures it. Input synchronisation and bus protocol handling belong to the surrounding logic.

Top module: `intc_status_router`

## Requirements
- R1: The raw status of a line equals its input pin when that line's polarity bit is 1, and the inverted pin when it is 0. In level mode the status shows the raw status sampled at the last clock edge, using the polarity that was in force before that edge.
- R2: A line's sticky bit is set at a clock edge where its raw status is 1 and the raw status captured at the previous edge was 0.
- R3: A sticky bit stays set, whatever the pin does, until it is cleared.
- R4: Status bit i shows the sticky bit when mode bit i is 1, and the level-mode raw status when it is 0.
- R5: A write with select 4 clears every sticky bit whose data bit is 1. If a new edge on that line arrives in the same cycle, the edge wins and the bit stays set.
- R6: A line is eligible only when both its status bit and its enable bit (select 2) are 1.
- R7: An eligible line whose fast-select bit (select 3) is 1 drives only the fast request. One whose fast-select bit is 0 drives only the normal request.
- R8: Each request is high when at least one line routed to it is eligible. Its index output carries the lowest-numbered such line, and 0 when the request is low.
- R9: The pending byte has the normal request in bit 7, the fast request in bit 6, and 0 in bits 5..0.
- R10: Reset sets every polarity bit to 1 and clears mode, enable, fast-select and sticky bits. It also clears the previous raw status, so a line that is active when reset ends registers as an edge at the first clock edge.
- R11: Write select codes are 0 polarity, 1 mode, 2 enable, 3 fast-select and 4 sticky clear. Codes 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_i | input | 32 | Interrupt input lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write target select |
| wr_data_i | input | 32 | Write data, one bit per line |
| status_o | output | 32 | Per-line reported status |
| nrm_req_o | output | 1 | Normal interrupt request |
| nrm_idx_o | output | 5 | Winning line of the normal request |
| fst_req_o | output | 1 | Fast interrupt request |
| fst_idx_o | output | 5 | Winning line of the fast request |
| pend_byte_o | output | 8 | Processor pending-interrupt byte |

## Verification
The lines are driven with several kinds of stimulus. A line held high through reset shows whether the previous-raw register really starts at zero. Single pulses against a later fall show whether latching is separate from live level. Inverting the polarity of one active line tells the polarity path apart from the mode path. A clear that coincides with a new edge exposes whether clear or set wins. Two lines enabled at once with different fast-select settings show that routing is separate from priority. A long run follows with random pin patterns and random configuration writes, including the unused select codes. In that run the bench compares status, both requests, both indexes and the pending byte on every clock against its behavioural model.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [2:0] {
        SEL_POLARITY = 3'd0,
        SEL_MODE     = 3'd1,
        SEL_ENABLE   = 3'd2,
        SEL_FAST     = 3'd3,
        SEL_CLEAR    = 3'd4
    } cfg_sel_e;

    localparam int PEND_NRM_BIT = 7;
    localparam int PEND_FST_BIT = 6;

endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [2:0]           wr_sel_i,
    input  logic [NUM_LINES-1:0] wr_data_i,
    output logic [NUM_LINES-1:0] pass_o,
    output logic [NUM_LINES-1:0] mode_o,
    output logic [NUM_LINES-1:0] en_o,
    output logic [NUM_LINES-1:0] fast_o,
    output logic [NUM_LINES-1:0] clr_o
);
    import intc_pkg::*;

    localparam int NUM_FIELDS = 4;

    logic [NUM_FIELDS-1:0]                field_we;
    logic [NUM_FIELDS-1:0][NUM_LINES-1:0] field_q;

    // field order follows the select codes 0..3
    localparam logic [NUM_FIELDS-1:0][NUM_LINES-1:0] FIELD_RST = '{
        '0, '0, '0, {NUM_LINES{1'b1}}
    };

    generate
        for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
            assign field_we[f] = wr_en_i && (wr_sel_i == 3'(f));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    field_q[f] <= FIELD_RST[f];
                end else if (field_we[f]) begin
                    field_q[f] <= wr_data_i;
                end
            end
        end
    endgenerate

    assign pass_o = field_q[SEL_POLARITY];
    assign mode_o = field_q[SEL_MODE];
    assign en_o   = field_q[SEL_ENABLE];
    assign fast_o = field_q[SEL_FAST];
    assign clr_o  = (wr_en_i && (wr_sel_i == SEL_CLEAR)) ? wr_data_i : '0;

endmodule

// File: rtl/intc_line_state.sv
module intc_line_state #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic [NUM_LINES-1:0] pass_i,
    input  logic [NUM_LINES-1:0] mode_i,
    input  logic [NUM_LINES-1:0] clr_i,
    output logic [NUM_LINES-1:0] status_o,
    output logic [NUM_LINES-1:0] sticky_o,
    output logic [NUM_LINES-1:0] edge_o
);
    logic [NUM_LINES-1:0] raw_now;
    logic [NUM_LINES-1:0] raw_q;
    logic [NUM_LINES-1:0] sticky_q;

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            assign raw_now[i] = line_i[i] ^ ~pass_i[i];
            assign edge_o[i]  = raw_now[i] & ~raw_q[i];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    raw_q[i]    <= 1'b0;
                    sticky_q[i] <= 1'b0;
                end else begin
                    raw_q[i]    <= raw_now[i];
                    sticky_q[i] <= (sticky_q[i] & ~clr_i[i]) | edge_o[i];
                end
            end

            assign status_o[i] = mode_i[i] ? sticky_q[i] : raw_q[i];
        end
    endgenerate

    assign sticky_o = sticky_q;

endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
    parameter int NUM_LINES = 32,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] req_vec_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     idx_o
);
    always_comb begin
        any_o = |req_vec_i;
        idx_o = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req_vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/intc_status_router.sv
module intc_status_router #(
    parameter int NUM_LINES = 32,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_i,
    input  logic                 wr_en_i,
    input  logic [2:0]           wr_sel_i,
    input  logic [NUM_LINES-1:0] wr_data_i,
    output logic [NUM_LINES-1:0] status_o,
    output logic                 nrm_req_o,
    output logic [IDX_W-1:0]     nrm_idx_o,
    output logic                 fst_req_o,
    output logic [IDX_W-1:0]     fst_idx_o,
    output logic [7:0]           pend_byte_o
);
    import intc_pkg::*;

    logic [NUM_LINES-1:0] pass_q;
    logic [NUM_LINES-1:0] mode_q;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] fast_q;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] sticky_q;
    logic [NUM_LINES-1:0] edge_vec;
    logic [NUM_LINES-1:0] elig_vec;
    logic [NUM_LINES-1:0] nrm_vec;
    logic [NUM_LINES-1:0] fst_vec;

    intc_cfg_regs #(.NUM_LINES(NUM_LINES)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .pass_o    (pass_q),
        .mode_o    (mode_q),
        .en_o      (en_q),
        .fast_o    (fast_q),
        .clr_o     (clr_vec)
    );

    intc_line_state #(.NUM_LINES(NUM_LINES)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .pass_i   (pass_q),
        .mode_i   (mode_q),
        .clr_i    (clr_vec),
        .status_o (status_o),
        .sticky_o (sticky_q),
        .edge_o   (edge_vec)
    );

    assign elig_vec = status_o & en_q;
    assign nrm_vec  = elig_vec & ~fast_q;
    assign fst_vec  = elig_vec & fast_q;

    intc_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick_nrm (
        .req_vec_i (nrm_vec),
        .any_o     (nrm_req_o),
        .idx_o     (nrm_idx_o)
    );

    intc_prio_pick #(.NUM_LINES(NUM_LINES)) u_pick_fst (
        .req_vec_i (fst_vec),
        .any_o     (fst_req_o),
        .idx_o     (fst_idx_o)
    );

    always_comb begin
        pend_byte_o               = '0;
        pend_byte_o[PEND_NRM_BIT] = nrm_req_o;
        pend_byte_o[PEND_FST_BIT] = fst_req_o;
    end

endmodule

// File: rtl/intc_status_router_chk.sv
module intc_status_router_chk #(
    parameter int NUM_LINES = 32,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic [2:0]           wr_sel_i,
    input logic [NUM_LINES-1:0] wr_data_i,
    input logic [NUM_LINES-1:0] status_o,
    input logic                 nrm_req_o,
    input logic [IDX_W-1:0]     nrm_idx_o,
    input logic                 fst_req_o,
    input logic [IDX_W-1:0]     fst_idx_o,
    input logic [NUM_LINES-1:0] en_q,
    input logic [NUM_LINES-1:0] fast_q,
    input logic [NUM_LINES-1:0] sticky_q,
    input logic [NUM_LINES-1:0] edge_vec
);
    localparam logic [NUM_LINES-1:0] ONE = NUM_LINES'(1);

    logic [NUM_LINES-1:0] chk_nrm;
    logic [NUM_LINES-1:0] chk_fst;
    logic                 clr_wr;

    assign chk_nrm = status_o & en_q & ~fast_q;
    assign chk_fst = status_o & en_q & fast_q;
    assign clr_wr  = wr_en_i && (wr_sel_i == 3'd4);

    a_r2_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_vec != '0) |=> ((sticky_q & $past(edge_vec)) == $past(edge_vec)));

    a_r3_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((sticky_q & $past(wr_data_i & ~edge_vec)) == '0));

    a_r7_nrm_routed: assert property (@(posedge clk) disable iff (!rst_n)
        nrm_req_o |-> (status_o[nrm_idx_o] && en_q[nrm_idx_o] && !fast_q[nrm_idx_o]));

    a_r7_fst_routed: assert property (@(posedge clk) disable iff (!rst_n)
        fst_req_o |-> (status_o[fst_idx_o] && en_q[fst_idx_o] && fast_q[fst_idx_o]));

    a_r8_nrm_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        nrm_req_o |-> ((chk_nrm & ((ONE << nrm_idx_o) - ONE)) == '0));

    a_r8_fst_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        fst_req_o |-> ((chk_fst & ((ONE << fst_idx_o) - ONE)) == '0));

    a_r8_idle_index: assert property (@(posedge clk) disable iff (!rst_n)
        !nrm_req_o |-> (nrm_idx_o == '0));

endmodule

bind intc_status_router intc_status_router_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .status_o  (status_o),
    .nrm_req_o (nrm_req_o),
    .nrm_idx_o (nrm_idx_o),
    .fst_req_o (fst_req_o),
    .fst_idx_o (fst_idx_o),
    .en_q      (en_q),
    .fast_q    (fast_q),
    .sticky_q  (sticky_q),
    .edge_vec  (edge_vec)
);

// File: tb/sim_intc_status_router.sv
module sim_intc_status_router;
    localparam int N     = 32;
    localparam int IW    = 5;
    localparam int CLK_P = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  lines = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [N-1:0]  wr_data = '0;
    logic [N-1:0]  status;
    logic          nrm_req, fst_req;
    logic [IW-1:0] nrm_idx, fst_idx;
    logic [7:0]    pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    intc_status_router #(.NUM_LINES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .line_i(lines),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .status_o(status), .nrm_req_o(nrm_req), .nrm_idx_o(nrm_idx),
        .fst_req_o(fst_req), .fst_idx_o(fst_idx), .pend_byte_o(pend)
    );

    // behavioural reference
    logic [N-1:0] m_pass = '1, m_mode = '0, m_en = '0, m_fast = '0;
    logic [N-1:0] m_stk = '0, m_rawq = '0;

    always @(posedge clk) begin
        logic [N-1:0] raw;
        if (!rst_n) begin
            m_pass = '1; m_mode = '0; m_en = '0; m_fast = '0;
            m_stk = '0; m_rawq = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                raw[i] = m_pass[i] ? lines[i] : ~lines[i];
                if (wr_en && wr_sel == 3'd4 && wr_data[i]) m_stk[i] = 1'b0;
                if (raw[i] && !m_rawq[i]) m_stk[i] = 1'b1;
            end
            m_rawq = raw;
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_pass = wr_data;
                    3'd1: m_mode = wr_data;
                    3'd2: m_en   = wr_data;
                    3'd3: m_fast = wr_data;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [N-1:0] st;
            bit en_n, en_f;
            int ix_n, ix_f;
            en_n = 0; en_f = 0; ix_n = 0; ix_f = 0;
            for (int i = 0; i < N; i++) begin
                st[i] = m_mode[i] ? m_stk[i] : m_rawq[i];
            end
            for (int i = 0; i < N; i++) begin
                if (st[i] && m_en[i]) begin
                    if (m_fast[i] && !en_f) begin en_f = 1; ix_f = i; end
                    if (!m_fast[i] && !en_n) begin en_n = 1; ix_n = i; end
                end
            end
            check("R4 status", status, st);
            check("R8 normal req", N'(nrm_req), N'(en_n));
            check("R8 normal idx", N'(nrm_idx), N'(ix_n));
            check("R7 fast req", N'(fst_req), N'(en_f));
            check("R7 fast idx", N'(fst_idx), N'(ix_f));
            check("R9 pending byte", N'(pend), N'({en_n, en_f, 6'b0}));
        end
    end

    // drive for one edge, return just after it with the write strobe dropped
    task automatic step(input logic [N-1:0] ln, input bit we, input logic [2:0] sel,
                        input logic [N-1:0] d);
        @(negedge clk); #1;
        lines = ln; wr_en = we; wr_sel = sel; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        lines = 32'h8;
        repeat (3) @(posedge clk);
        #2;
        check("R10 reset status", status, '0);
        check("R10 reset requests", N'({nrm_req, fst_req}), '0);
        @(negedge clk); rst_n = 1'b1;
        // R10: line 3 active through reset becomes an edge on the first clock
        step(32'h8, 1, 3'd1, '1);
        check("R10 edge after reset", status, 32'h8);
        step(32'h8, 1, 3'd2, '1);
        check("R6 enabled line requests", N'(nrm_req), 1);
        check("R8 winning index", N'(nrm_idx), 3);
        step(32'h0, 1, 3'd4, 32'h8);
        check("R5 clear by writing one", status, '0);
        step(32'h0, 1, 3'd1, '0);
        step(32'h500, 0, 3'd0, '0);
        check("R1 level follows pins", status, 32'h500);
        check("R8 lowest of two", N'(nrm_idx), 8);
        step(32'h500, 1, 3'd0, ~32'h100);
        check("R1 old polarity used at write edge", status, 32'h500);
        step(32'h500, 0, 3'd0, '0);
        check("R1 inverted line", status, 32'h400);
        step(32'h500, 1, 3'd3, 32'h400);
        check("R7 fast routing", N'({nrm_req, fst_req}), 2'b01);
        check("R9 fast pending bit", N'(pend), 32'h40);
        step(32'h0, 0, 3'd0, '0);
        check("R1 inverted idle line active", status, 32'h100);
        check("R9 normal pending bit", N'(pend), 32'h80);
        step(32'h0, 1, 3'd0, '1);
        step(32'h0, 1, 3'd1, '1);
        step(32'h0, 1, 3'd4, '1);
        check("R5 clear all", status, '0);
        step(32'h20, 0, 3'd0, '0);
        check("R2 edge latched", status, 32'h20);
        step(32'h0, 0, 3'd0, '0);
        check("R3 latched after fall", status, 32'h20);
        step(32'h20, 1, 3'd4, 32'h20);
        check("R5 edge beats clear", status, 32'h20);
        step(32'h20, 1, 3'd4, 32'h20);
        check("R5 clear without edge", status, '0);
        step(32'h0, 1, 3'd5, '1);
        step(32'h0, 1, 3'd7, '1);
        step(32'h1, 0, 3'd0, '0);
        check("R11 unused codes ignored", status, 32'h1);
        for (int k = 0; k < 600; k++) begin
            logic [N-1:0] ln;
            ln = $urandom();
            if ($urandom_range(0, 3) == 0)
                step(ln, 1, 3'($urandom_range(0, 7)), $urandom());
            else
                step(ln, 0, 3'd0, '0);
        end
        @(negedge clk); #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule